// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block walks a word address through memory for one channel of a two-dimensional DMA engine. Software supplies a start word address, a line length, a line count and a line stride, all in 4-byte words. A start pulse launches the walk. The block then offers one word request per step toward a memory port over a valid/ready handshake. It reports the end of a rectangular frame with a one-cycle completion pulse.

A line length of zero selects ring mode. In ring mode the block circulates without end over an area of stride × (line count + 1) words, returning to the start address after the last word. It pulses a half event at the end of each half of that area, with a flag that names the half, so a consumer can refill one half while the other is in use. Ring mode ends when the loop enable is low at an accepted word. A stop input ends any walk at once.

The direction and burst-mode choices are captured at start and carried on every request. The live word address is always readable, so software can work out how many bytes remain.

Back-pressure rules: a request is accepted in a cycle where `req_valid` and `req_ready` are both high. While `req_ready` is low, `req_valid` stays high and `req_addr`, `req_to_dev` and `req_burst4` hold their values. The only exception is a cycle with `stop` high. The block never withdraws a request for any other reason. `req_ready` may be high in any cycle, including cycles with no request.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `busy`, `req_valid`, `done` and `half_evt` are low and `cur_addr` is 0.
- R2: With `line_len` nonzero, the requests form `line_cnt`+1 lines of `line_len` consecutive word addresses. Line k starts at `base_addr` + k·`line_step`.
- R3: In frame mode, `done` is high for exactly one cycle, in the cycle after the last word of the last line is accepted. From that cycle on, `busy` is low and `cur_addr` equals the last word address plus one.
- R4: While `req_valid` is high and `req_ready` is low, the next cycle keeps `req_valid` high with the same `req_addr`, unless `stop` is high in that next cycle.
- R5: With `line_len` zero, the requests are `base_addr` + (n mod A) for the n-th accepted word, where A = `line_step`·(`line_cnt`+1). A must be even and at least 2.
- R6: In ring mode, `half_evt` pulses for one cycle after the word at offset A/2−1 is accepted, with `half_second`=0. It also pulses after the word at offset A−1 is accepted, with `half_second`=1. There are no other half events.
- R7: In ring mode, when `loop_en` is low in the cycle a word is accepted, the walk ends after that word. `busy` then drops with no `done` pulse.
- R8: In a cycle with `stop` high, `req_valid` is low. The next cycle is idle, and no `done` or `half_evt` follows.
- R9: A `start` pulse while `busy` is high has no effect on the request sequence.
- R10: `req_to_dev` and `req_burst4` carry the `dir_to_dev` and `burst4` values sampled at start. Later changes to those inputs do not alter them.
- R11: While `busy`, `cur_addr` equals `req_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a walk when idle |
| stop | input | 1 | Abort at once, return to idle |
| loop_en | input | 1 | Keep ring mode running |
| base_addr | input | AW | Start word address (byte address >> 2) |
| line_len | input | LW | Words per line; 0 selects ring mode |
| line_cnt | input | LW | Number of lines minus one |
| line_step | input | LW | Words between line starts |
| dir_to_dev | input | 1 | 1 = memory to device, 0 = device to memory |
| burst4 | input | 1 | 4-word burst mode select |
| req_valid | output | 1 | Word request offered |
| req_ready | input | 1 | Memory port accepts the request |
| req_addr | output | AW | Word address of the request |
| req_to_dev | output | 1 | Latched direction |
| req_burst4 | output | 1 | Latched burst mode |
| cur_addr | output | AW | Live word address |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Frame completion pulse |
| half_evt | output | 1 | Ring half-boundary pulse |
| half_second | output | 1 | Half named by the last half event |

## Verification
The bench targets the line turn, where a design that reloads from the wrong base would skip or repeat a stride. It also targets the final word, where an off-by-one count would drop the last line or pulse `done` early. Under back-pressure it checks that the address holds, because a sequencer that advances without a handshake loses words. In ring mode it checks the wrap and both half pulses over several laps, which would catch a wrap to the wrong address or a half pulse on the wrong word. It also covers the loop exit, a stop in mid-frame, a start while busy and changes to the direction and burst inputs after start. A flawed block would raise a stray completion after an abort, or let the request flags follow live inputs.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic {
    WALK_FRAME = 1'b0,
    WALK_RING  = 1'b1
  } walk_mode_e;
endpackage

// File: rtl/dma2d_down_ctr.sv
module dma2d_down_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] value,
  output logic         zero
);
  always_ff @(posedge clk) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= load_val;
    else if (dec)  value <= value - 1'b1;
  end
  assign zero = (value == '0);
endmodule

// File: rtl/dma2d_ring_pos.sv
module dma2d_ring_pos #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] area,
  output logic         at_half,
  output logic         at_end
);
  logic [W-1:0] pos;
  logic [W-1:0] half_last;

  assign half_last = (area >> 1) - 1'b1;
  assign at_half   = (pos == half_last);
  assign at_end    = (pos == area - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)      pos <= '0;
    else if (clear)  pos <= '0;
    else if (step)   pos <= at_end ? '0 : pos + 1'b1;
  end

  // R5
  ring_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (pos < area));
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          loop_en,
  input  logic [AW-1:0] base_addr,
  input  logic [LW-1:0] line_len,
  input  logic [LW-1:0] line_cnt,
  input  logic [LW-1:0] line_step,
  input  logic          dir_to_dev,
  input  logic          burst4,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic          req_to_dev,
  output logic          req_burst4,
  output logic [AW-1:0] cur_addr,
  output logic          busy,
  output logic          done,
  output logic          half_evt,
  output logic          half_second
);
  localparam int AREA_W = 2 * LW + 1;

  logic              running;
  walk_mode_e        mode_q;
  logic [AW-1:0]     addr_q, line_start_q, base_q;
  logic [LW-1:0]     len_q, step_q;
  logic [AREA_W-1:0] area_q;
  logic              to_dev_q, burst_q, done_q, half_q, half2_q;

  logic launch, accept, in_frame, in_ring;
  logic x_zero, y_zero, r_half, r_end;
  logic x_load, x_dec, y_dec;
  logic [LW-1:0] x_val, x_cnt, y_cnt;
  logic [AW-1:0] next_line;

  assign launch    = !running && start && !stop;
  assign req_valid = running && !stop;
  assign accept    = req_valid && req_ready;
  assign in_frame  = (mode_q == WALK_FRAME);
  assign in_ring   = (mode_q == WALK_RING);
  assign next_line = line_start_q + AW'(step_q);

  assign x_load = launch || (accept && in_frame && x_zero && !y_zero);
  assign x_val  = (launch ? line_len : len_q) - 1'b1;
  assign x_dec  = accept && in_frame && !x_zero;
  assign y_dec  = accept && in_frame && x_zero && !y_zero;

  dma2d_down_ctr #(.W(LW)) u_xctr (
    .clk(clk), .rst_n(rst_n), .load(x_load), .load_val(x_val),
    .dec(x_dec), .value(x_cnt), .zero(x_zero));

  dma2d_down_ctr #(.W(LW)) u_yctr (
    .clk(clk), .rst_n(rst_n), .load(launch), .load_val(line_cnt),
    .dec(y_dec), .value(y_cnt), .zero(y_zero));

  dma2d_ring_pos #(.W(AREA_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .clear(launch), .step(accept && in_ring),
    .area(area_q), .at_half(r_half), .at_end(r_end));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running      <= 1'b0;
      mode_q       <= WALK_FRAME;
      addr_q       <= '0;
      line_start_q <= '0;
      base_q       <= '0;
      len_q        <= '0;
      step_q       <= '0;
      area_q       <= '0;
      to_dev_q     <= 1'b0;
      burst_q      <= 1'b0;
      done_q       <= 1'b0;
      half_q       <= 1'b0;
      half2_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      half_q <= 1'b0;
      if (stop) begin
        running <= 1'b0;
      end else if (launch) begin
        running      <= 1'b1;
        mode_q       <= (line_len == '0) ? WALK_RING : WALK_FRAME;
        addr_q       <= base_addr;
        line_start_q <= base_addr;
        base_q       <= base_addr;
        len_q        <= line_len;
        step_q       <= line_step;
        area_q       <= AREA_W'(line_step) * (AREA_W'(line_cnt) + 1'b1);
        to_dev_q     <= dir_to_dev;
        burst_q      <= burst4;
      end else if (accept) begin
        if (in_frame) begin
          if (!x_zero) begin
            addr_q <= addr_q + 1'b1;
          end else if (y_zero) begin
            addr_q  <= addr_q + 1'b1;
            running <= 1'b0;
            done_q  <= 1'b1;
          end else begin
            addr_q       <= next_line;
            line_start_q <= next_line;
          end
        end else begin
          if (r_end) begin
            addr_q  <= base_q;
            half_q  <= 1'b1;
            half2_q <= 1'b1;
          end else begin
            addr_q <= addr_q + 1'b1;
            if (r_half) begin
              half_q  <= 1'b1;
              half2_q <= 1'b0;
            end
          end
          if (!loop_en) running <= 1'b0;
        end
      end
    end
  end

  assign req_addr    = addr_q;
  assign cur_addr    = addr_q;
  assign req_to_dev  = to_dev_q;
  assign req_burst4  = burst_q;
  assign busy        = running;
  assign done        = done_q;
  assign half_evt    = half_q;
  assign half_second = half2_q;

  // R4
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid || stop));

  // R4
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (stop || $stable(req_addr)));

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!busy && !done && !half_evt));

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && half_evt));

  // R10
  flags_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(req_to_dev) && $stable(req_burst4)));
endmodule

// File: tb/sim_dma2d_addr_gen.sv
module sim_dma2d_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, stop = 1'b0, loop_en = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] line_len = '0, line_cnt = '0, line_step = '0;
  logic        dir_to_dev = 1'b0, burst4 = 1'b0, req_ready = 1'b0;
  logic        req_valid, req_to_dev, req_burst4, busy, done, half_evt, half_second;
  logic [31:0] req_addr, cur_addr;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  dma2d_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .loop_en(loop_en),
    .base_addr(base_addr), .line_len(line_len), .line_cnt(line_cnt),
    .line_step(line_step), .dir_to_dev(dir_to_dev), .burst4(burst4),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_to_dev(req_to_dev), .req_burst4(req_burst4), .cur_addr(cur_addr),
    .busy(busy), .done(done), .half_evt(half_evt), .half_second(half_second));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] b, input logic [15:0] len,
                        input logic [15:0] cnt, input logic [15:0] stp,
                        input logic d, input logic bu);
    base_addr = b; line_len = len; line_cnt = cnt; line_step = stp;
    dir_to_dev = d; burst4 = bu; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic test_reset();
    chk(!busy, "R1", "busy", busy, 0);
    chk(!req_valid, "R1", "req_valid", req_valid, 0);
    chk(!done && !half_evt, "R1", "pulses", done | half_evt, 0);
    chk(cur_addr == 0, "R1", "cur_addr", cur_addr, 0);
  endtask

  // R2 R3 R4 R9 R11
  task automatic test_frame(input int b, input int len, input int cnt,
                            input int stp, input int rmod, input bit poke);
    int idx = 0;
    int total = len * (cnt + 1);
    int dones = 0;
    bit held = 0;
    bit fin = 0;
    logic [31:0] held_addr = '0;
    logic [31:0] last = '0;
    launch(b, len[15:0], cnt[15:0], stp[15:0], 1'b0, 1'b0);
    for (int cyc = 0; cyc < total * 4 + 20 && !fin; cyc++) begin
      req_ready = (rmod == 0) || (cyc % rmod != 0);
      if (poke && cyc == 2) begin
        base_addr = 32'd9000; line_len = 16'd1; start = 1'b1;
      end else start = 1'b0;
      #1;
      if (held) begin
        chk(req_valid, "R4", "valid held", req_valid, 1);
        chk(req_addr == held_addr, "R4", "addr held", req_addr, held_addr);
      end
      if (done) begin
        dones++;
        chk(idx == total, "R3", "words before done", idx, total);
        chk(!busy, "R3", "busy at done", busy, 0);
        chk(cur_addr == last + 1, "R3", "cur_addr after frame", cur_addr, last + 1);
        fin = 1;
      end
      if (req_valid) begin
        chk(cur_addr == req_addr, "R11", "cur_addr", cur_addr, req_addr);
      end
      if (req_valid && req_ready) begin
        last = 32'(b + (idx / len) * stp + (idx % len));
        chk(req_addr == last, poke ? "R9" : "R2", "word address", req_addr, last);
        idx++;
      end
      held = req_valid && !req_ready;
      held_addr = req_addr;
      @(negedge clk);
    end
    start = 1'b0;
    chk(dones == 1, "R3", "done count", dones, 1);
    #1;
    chk(!done && !busy, "R3", "done one cycle", done, 0);
    @(negedge clk);
  endtask

  // R5 R6 R7
  task automatic test_ring();
    int n = 0;
    int prev = -1;
    int evts = 0;
    logic [31:0] exp;
    loop_en = 1'b1;
    launch(32'd200, 16'd0, 16'd3, 16'd4, 1'b1, 1'b0);
    for (int cyc = 0; n < 40 && cyc < 400; cyc++) begin
      req_ready = (cyc % 3 != 1);
      #1;
      chk(half_evt == (prev == 7 || prev == 15), "R6", "half_evt", half_evt,
          (prev == 7 || prev == 15));
      if (half_evt) begin
        evts++;
        chk(half_second == (prev == 15), "R6", "half_second", half_second, prev == 15);
      end
      chk(!done, "R5", "no done in ring", done, 0);
      if (req_valid && req_ready) begin
        exp = 32'd200 + 32'(n % 16);
        chk(req_addr == exp, "R5", "ring address", req_addr, exp);
        prev = n % 16;
        n++;
      end else prev = -1;
      @(negedge clk);
    end
    req_ready = 1'b0;
    loop_en = 1'b0;
    #1;
    chk(half_evt && !half_second, "R6", "last half event", half_evt, 1);
    evts++;
    chk(evts == 5, "R6", "event count", evts, 5);
    chk(busy, "R7", "still busy without accept", busy, 1);
    @(negedge clk);
    req_ready = 1'b1;
    #1;
    chk(req_valid && req_addr == 32'd208, "R7", "exit word", req_addr, 208);
    @(negedge clk);
    req_ready = 1'b0;
    #1;
    chk(!busy && !req_valid, "R7", "idle after exit", busy, 0);
    chk(!done, "R7", "no done on exit", done, 0);
    chk(cur_addr == 32'd209, "R7", "cur_addr after exit", cur_addr, 209);
    @(negedge clk);
  endtask

  // R8
  task automatic test_stop();
    int hits = 0;
    req_ready = 1'b1;
    launch(32'd50, 16'd4, 16'd3, 16'd8, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    stop = 1'b1;
    #1;
    chk(!req_valid, "R8", "valid during stop", req_valid, 0);
    @(negedge clk);
    stop = 1'b0;
    #1;
    chk(!busy && !req_valid, "R8", "idle after stop", busy, 0);
    for (int k = 0; k < 4; k++) begin
      if (done || half_evt) hits++;
      @(negedge clk);
      #1;
    end
    chk(hits == 0, "R8", "no event after stop", hits, 0);
    req_ready = 1'b0;
    @(negedge clk);
  endtask

  // R10
  task automatic test_flags();
    req_ready = 1'b0;
    launch(32'd10, 16'd2, 16'd0, 16'd2, 1'b1, 1'b1);
    dir_to_dev = 1'b0; burst4 = 1'b0;
    #1;
    chk(req_to_dev == 1'b1, "R10", "to_dev latched", req_to_dev, 1);
    chk(req_burst4 == 1'b1, "R10", "burst latched", req_burst4, 1);
    @(negedge clk);
    #1;
    chk(req_to_dev && req_burst4, "R10", "flags held", {req_to_dev, req_burst4}, 3);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    launch(32'd10, 16'd2, 16'd0, 16'd2, 1'b0, 1'b0);
    dir_to_dev = 1'b1; burst4 = 1'b1;
    #1;
    chk(!req_to_dev && !req_burst4, "R10", "flags low latched",
        {req_to_dev, req_burst4}, 0);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_frame(100, 3, 2, 5, 0, 0);
    test_frame(100, 3, 2, 5, 3, 0);
    test_frame(7, 1, 0, 3, 0, 0);
    test_frame(300, 4, 3, 10, 2, 1);
    test_ring();
    test_stop();
    test_flags();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule